// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block sits behind eight independent serial receivers and merges their received characters into one shared first-in first-out buffer. Each stored word carries the character, the three-bit number of the line it arrived on and that character's parity, framing and overrun flags. Software drains the buffer through one read-only data port. Every read pops one word. Bit 15 of a word marks it as holding a character, so a driver keeps reading while the value is negative when taken as a signed 16-bit number.

A line offers a character by raising its valid bit and holds the valid bit, character and flags until the silo acknowledges it. The silo takes at most one line per cycle. When several lines offer at once, it visits them round-robin. A control register holds three settings: a scan enable that gates all collection, a receive interrupt enable, and an alarm enable. In per-character mode the interrupt is raised while anything is waiting. In alarm mode it is raised only once the buffer holds sixteen or more entries, and a periodic poll is expected to collect any remainder.

Top module: `rx_silo`

## Requirements
- R1: After reset the silo is empty, `rbuf_data_o` reads 0, `rx_irq_o` is low and no line is acknowledged, whatever the lines offer.
- R2: A stored word read out has bit 15 = 1, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bit 11 = 0, bits 10:8 = line number and bits 7:0 = character.
- R3: A line is acknowledged on `ln_ack_o` in the same cycle it is taken. At most one acknowledge bit is high per cycle, and only for a line whose valid bit is high.
- R4: When several lines are valid, the first valid line after the most recently taken line (counting upward, modulo 8) is taken. After reset the search starts at line 0.
- R5: Words are read back in the order they were taken. A read with `rbuf_rd_i` high pops the head word, which is presented on `rbuf_data_o` before the pop. Reading an empty silo returns 0.
- R6: The silo holds 64 words. A character taken while it is full is acknowledged and discarded, and the next word stored for that same line has its overrun bit set. Other lines' words do not get that bit.
- R7: Control bit 5 (scan enable) low means no line is acknowledged, and the silo is empty from the second clock edge after the bit is cleared.
- R8: With control bit 12 low, `rx_irq_o` is high exactly when control bit 6 is set and the silo is non-empty.
- R9: With control bits 12 and 6 set, `rx_irq_o` rises one cycle after the fill first reaches 16. Any read drops it on the next edge. It can rise again only after that read.
- R10: Control bits other than 5, 6 and 12 have no effect. Writing them alone leaves collection disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln_valid_i | input | 8 | Per-line character offered |
| ln_char_i | input | 64 | Per-line character, line n in bits 8n+7:8n |
| ln_perr_i | input | 8 | Per-line parity error flag |
| ln_ferr_i | input | 8 | Per-line framing error (break) flag |
| ln_ack_o | output | 8 | Per-line capture acknowledge |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 16 | Control register write data |
| rbuf_rd_i | input | 1 | Receive buffer read (pop) strobe |
| rbuf_data_o | output | 16 | Head word, or 0 when empty |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
A wrong round-robin pointer shows up in the cycle of the next contended request, as an acknowledge on the wrong line. It shows up again at drain time as a line tag out of order. A corrupted count or pointer appears as a wrong word, or a lost or extra word, on the first read that reaches it, and as an interrupt edge one cycle early or late against the fill of 16. A lost or misplaced overrun marker is visible only on the word stored for that line after the buffer stops being full, so the bench fills the buffer completely, drops characters, and then drains every word.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int TAG_W    = 3;
  localparam int CHAR_W   = 8;
  localparam int LINES    = 1 << TAG_W;
  localparam int CTL_W    = 16;
  localparam int RBUF_W   = 16;
  localparam int ENTRY_W  = RBUF_W - 1;

  localparam int CTL_SCAN_BIT  = 5;
  localparam int CTL_RXIE_BIT  = 6;
  localparam int CTL_ALARM_BIT = 12;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic              spare;
    logic [TAG_W-1:0]  tag;
    logic [CHAR_W-1:0] ch;
  } entry_t;
endpackage

// File: rtl/rx_silo_arb.sv
module rx_silo_arb #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] gidx_o,
  output logic          gvalid_o
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    gvalid_o = 1'b0;
    gidx_o   = last_q;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last_q) + off) % N;
      if (!gvalid_o && en_i && req_i[cand]) begin
        gvalid_o = 1'b1;
        gidx_o   = IW'(cand);
      end
    end
    grant_o = gvalid_o ? (N'(1) << gidx_o) : '0;
    last_d  = gvalid_o ? gidx_o : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_grant_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0);
  p_rr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gvalid_o |=> last_q == $past(gidx_o));
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter  int W     = 15,
  parameter  int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (int'(cnt_q) == DEPTH);
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign dout_o  = mem[rd_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = bump(wr_q);
      if (do_pop)  rd_d = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i && !flush_i) |=> full_o);
  p_empty_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/rx_silo_irq.sv
module rx_silo_irq #(
  parameter int CNT_W  = 7,
  parameter int THRESH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             rd_i,
  input  logic             rxie_i,
  input  logic             alarm_en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             empty_i,
  output logic             irq_o
);
  logic alarm_q, alarm_d, armed_q, armed_d;

  always_comb begin
    alarm_d = alarm_q;
    armed_d = armed_q;
    if (flush_i || rd_i) begin
      alarm_d = 1'b0;
      armed_d = 1'b1;
    end else if (armed_q && (count_i >= CNT_W'(THRESH))) begin
      alarm_d = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      alarm_q <= alarm_d;
      armed_q <= armed_d;
    end
  end

  assign irq_o = rxie_i && (alarm_en_i ? alarm_q : !empty_i);

  p_alarm_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(count_i) >= CNT_W'(THRESH));
  p_alarm_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !alarm_q);
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter  int DEPTH     = 64,
  parameter  int ALARM_LVL = 16,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         ln_valid_i,
  input  logic [LINES*CHAR_W-1:0]  ln_char_i,
  input  logic [LINES-1:0]         ln_perr_i,
  input  logic [LINES-1:0]         ln_ferr_i,
  output logic [LINES-1:0]         ln_ack_o,
  input  logic                     ctl_we_i,
  input  logic [CTL_W-1:0]         ctl_wdata_i,
  input  logic                     rbuf_rd_i,
  output logic [RBUF_W-1:0]        rbuf_data_o,
  output logic                     rx_irq_o
);
  logic             rst_meta_q, rst_sync_q;
  logic             scan_q, rxie_q, alarm_en_q;
  logic             scan_d, rxie_d, alarm_en_d;
  logic [LINES-1:0] grant;
  logic [TAG_W-1:0] gidx;
  logic             gvalid;
  logic [LINES-1:0] ovr_q, ovr_d;
  entry_t           new_entry, head;
  logic [ENTRY_W-1:0] head_raw;
  logic [CNT_W-1:0] count;
  logic             full, empty, flush, pop;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // control register
  always_comb begin
    scan_d     = scan_q;
    rxie_d     = rxie_q;
    alarm_en_d = alarm_en_q;
    if (ctl_we_i) begin
      scan_d     = ctl_wdata_i[CTL_SCAN_BIT];
      rxie_d     = ctl_wdata_i[CTL_RXIE_BIT];
      alarm_en_d = ctl_wdata_i[CTL_ALARM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      scan_q     <= 1'b0;
      rxie_q     <= 1'b0;
      alarm_en_q <= 1'b0;
    end else begin
      scan_q     <= scan_d;
      rxie_q     <= rxie_d;
      alarm_en_q <= alarm_en_d;
    end
  end

  assign flush = !scan_q;

  rx_silo_arb #(.N(LINES)) u_arb (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .en_i     (scan_q),
    .req_i    (ln_valid_i),
    .grant_o  (grant),
    .gidx_o   (gidx),
    .gvalid_o (gvalid)
  );

  assign ln_ack_o = grant;

  // entry formatting
  always_comb begin
    new_entry.ovr   = ovr_q[gidx];
    new_entry.ferr  = ln_ferr_i[gidx];
    new_entry.perr  = ln_perr_i[gidx];
    new_entry.spare = 1'b0;
    new_entry.tag   = gidx;
    new_entry.ch    = ln_char_i[int'(gidx)*CHAR_W +: CHAR_W];
  end

  // per-line overrun markers
  for (genvar l = 0; l < LINES; l++) begin : g_ovr
    always_comb begin
      ovr_d[l] = ovr_q[l];
      if (flush)         ovr_d[l] = 1'b0;
      else if (grant[l]) ovr_d[l] = full;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) ovr_q <= '0;
    else             ovr_q <= ovr_d;
  end

  assign pop = rbuf_rd_i && !empty;

  rx_silo_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .flush_i (flush),
    .push_i  (gvalid),
    .din_i   (new_entry),
    .pop_i   (pop),
    .dout_o  (head_raw),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  assign head        = entry_t'(head_raw);
  assign rbuf_data_o = empty ? '0 : {1'b1, head};

  rx_silo_irq #(.CNT_W(CNT_W), .THRESH(ALARM_LVL)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .flush_i    (flush),
    .rd_i       (rbuf_rd_i),
    .rxie_i     (rxie_q),
    .alarm_en_i (alarm_en_q),
    .count_i    (count),
    .empty_i    (empty),
    .irq_o      (rx_irq_o)
  );

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !scan_q |=> (count == '0));
  p_ack_scan_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (|ln_ack_o) |-> scan_q);
  p_ovr_after_drop_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (gvalid && full && scan_q) |=> ovr_q[$past(gidx)]);
endmodule

// File: tb/rx_silo_bench.sv
module rx_silo_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ln_valid;
  logic [63:0] ln_char;
  logic [7:0]  ln_perr, ln_ferr, ln_ack;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        rbuf_rd;
  logic [15:0] rbuf_data;
  logic        rx_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rx_silo u_rx_silo (
    .clk(clk), .rst_n(rst_n), .ln_valid_i(ln_valid), .ln_char_i(ln_char),
    .ln_perr_i(ln_perr), .ln_ferr_i(ln_ferr), .ln_ack_o(ln_ack),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .rbuf_rd_i(rbuf_rd),
    .rbuf_data_o(rbuf_data), .rx_irq_o(rx_irq)
  );

  // {valid mask, parity mask, framing mask, expected ack}
  localparam logic [31:0] VEC [10] = '{
    32'h01_00_00_01, 32'h81_00_00_80, 32'h81_00_00_01, 32'h24_04_00_04,
    32'h24_00_20_20, 32'h00_00_00_00, 32'hFF_00_00_40, 32'h08_00_00_08,
    32'h12_10_10_10, 32'hFF_00_00_20
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [15:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic push(input int l, input logic [7:0] c, input logic pe,
                      input logic fe, input string req);
    @(negedge clk);
    ln_valid = 8'(1 << l); ln_char = {8{c}};
    ln_perr = pe ? 8'(1 << l) : 8'h00; ln_ferr = fe ? 8'(1 << l) : 8'h00;
    #1 chk(req, {8'h00, ln_ack}, {8'h00, 8'(1 << l)});
    @(negedge clk);
    ln_valid = '0; ln_perr = '0; ln_ferr = '0;
  endtask

  task automatic rd(output logic [15:0] d);
    @(negedge clk);
    rbuf_rd = 1'b1;
    #1 d = rbuf_data;
    @(negedge clk);
    rbuf_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] expv [16];
    logic [15:0] d;
    int n;
    rst_n = 1'b0; ln_valid = 8'hFF; ln_char = '0; ln_perr = '0; ln_ferr = '0;
    ctl_we = 1'b0; ctl_wdata = '0; rbuf_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ack", {8'h00, ln_ack}, 16'h0000);
    chk("R1 rbuf", rbuf_data, 16'h0000);
    chk("R1 irq", {15'd0, rx_irq}, 16'h0000);

    // R10: unrelated control bits do not enable scanning
    ctl(16'hEF9F);
    @(negedge clk);
    #1 chk("R10 ack", {8'h00, ln_ack}, 16'h0000);
    ln_valid = '0;

    // R3/R4: vector walk with scan and per-character interrupt enabled
    ctl(16'h0060);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ln_valid = VEC[i][31:24]; ln_perr = VEC[i][23:16]; ln_ferr = VEC[i][15:8];
      ln_char  = {8{8'(8'h60 + i)}};
      #1 chk("R3 R4 ack", {8'h00, ln_ack}, {8'h00, VEC[i][7:0]});
      for (int l = 0; l < 8; l++) begin
        if (VEC[i][l]) begin
          expv[n] = {1'b1, 1'b0, VEC[i][8+l], VEC[i][16+l], 1'b0, 3'(l), 8'(8'h60 + i)};
          n++;
        end
      end
    end
    @(negedge clk);
    ln_valid = '0; ln_perr = '0; ln_ferr = '0;
    chk("R8 irq nonempty", {15'd0, rx_irq}, 16'h0001);
    // R2/R5: drain in order with correct format
    for (int k = 0; k < n; k++) begin
      rd(d);
      chk("R2 R5 word", d, expv[k]);
    end
    chk("R8 irq empty", {15'd0, rx_irq}, 16'h0000);
    rd(d);
    chk("R5 empty read", d, 16'h0000);

    // R8: interrupt enable gating
    ctl(16'h0020);
    push(3, 8'h41, 1'b0, 1'b0, "R3 push");
    chk("R8 irq disabled", {15'd0, rx_irq}, 16'h0000);
    ctl(16'h0060);
    chk("R8 irq enabled", {15'd0, rx_irq}, 16'h0001);

    // R7: clearing scan flushes and blocks capture
    ctl(16'h0040);
    @(negedge clk);
    chk("R7 flushed", rbuf_data, 16'h0000);
    ln_valid = 8'h10;
    #1 chk("R7 no ack", {8'h00, ln_ack}, 16'h0000);
    ln_valid = '0;
    ctl(16'h0060);
    chk("R7 still empty", rbuf_data, 16'h0000);

    // R9: alarm mode
    ctl(16'h1060);
    for (int i = 0; i < 16; i++) begin
      push(1, 8'(i), 1'b0, 1'b0, "R3 fill");
      if (i < 15) begin
        if (rx_irq !== 1'b0) chk("R9 early alarm", {15'd0, rx_irq}, 16'h0000);
      end
    end
    chk("R9 alarm not yet", {15'd0, rx_irq}, 16'h0000);
    @(negedge clk);
    chk("R9 alarm raised", {15'd0, rx_irq}, 16'h0001);

    // R6: fill to 64, then drop
    for (int i = 16; i < 64; i++) push(1, 8'(i), 1'b0, 1'b0, "R6 fill");
    push(1, 8'h99, 1'b0, 1'b0, "R6 drop ack");
    rd(d);
    chk("R6 head", d, 16'h8100);
    chk("R9 cleared by read", {15'd0, rx_irq}, 16'h0000);
    rd(d);
    chk("R6 head2", d, 16'h8101);
    push(2, 8'h5A, 1'b0, 1'b0, "R6 other line");
    push(1, 8'h77, 1'b0, 1'b0, "R6 same line");
    for (int i = 2; i < 64; i++) begin
      rd(d);
      if (d !== (16'h8100 | 16'(i))) chk("R6 R5 fill word", d, 16'h8100 | 16'(i));
    end
    checks++;
    rd(d);
    chk("R6 no overrun other line", d, 16'h825A);
    rd(d);
    chk("R6 overrun marked", d, 16'hC177);
    rd(d);
    chk("R5 empty after drain", d, 16'h0000);
    @(negedge clk);
    chk("R9 idle after drain", {15'd0, rx_irq}, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule